// File: doc/BRIEF.md
# Link GPIO Slot Mirror

This block keeps two host-visible registers in step with the general-purpose I/O slot (slot 12) of an AC'97-style serial link that carries modem-codec GPIO. The link framer is outside the block. It presents one frame at a time as parallel words, marked by a single-cycle frame strobe. Those words are the received tag, the received slot 1 word that carries the codec's slot-request bits, and the received slot 12 payload. A slot-enable input gates all mirroring in both directions.

In the input direction, the block copies the received slot 12 payload into an input-data register, but only for frames whose tag marks slot 12 valid. Bit 0 of that payload is the codec's GPIO interrupt line, and it sets a sticky interrupt status bit. In the output direction, the block presents an output-data register as the outgoing slot 12 payload. It sets the outgoing slot 12 tag bit only when the codec asked for slot 12 in the frame before. Software reaches the registers through a plain write port and a registered read port.

Top module: `acl_gpio_shadow`

## Requirements
- R1: After a synchronous reset, `tx_slot_tag`, `tx_slot_data`, `irq` and `rd_data` are 0. Every register reads 0: input data at address 0, output data at address 1, status at address 2 and control at address 3.
- R2: At a frame strobe where `slot_en` is 1 and tag bit 3 (the slot 12 valid flag) is 1, the input-data register takes `rx_slot12[19:0]`. A read of address 0 returns it zero-extended to 32 bits.
- R3: At a frame strobe where tag bit 3 is 0, the input-data register keeps its previous value.
- R4: At frame strobe k, `tx_slot_tag` becomes 1 only if `slot_en` is 1 and `rx_slot1` bit 2 (the codec's slot 12 request) was 1 at frame strobe k-1. Otherwise it becomes 0. It changes only at frame strobes.
- R5: A write to address 1 updates the output-data register at once, and a read returns that value. `tx_slot_data` takes the register value only at the next frame strobe and holds it until the strobe after that.
- R6: Status bit 0 (address 2) is set by a captured frame whose slot 12 bit 0 is 1. It stays set until a write of 1 to bit 0 clears it. If a set and a clear fall in the same cycle, the set wins.
- R7: `irq` is status bit 0 AND control bit 0 (address 3). It updates on the same edge as the bits it depends on.
- R8: At a frame strobe with `slot_en` at 0, no capture happens, the status bit is not set, and `tx_slot_tag` becomes 0.
- R9: `rd_data` is registered. It shows the register selected by `rd_addr` one clock edge after the address is applied, and it does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | One-cycle strobe: the rx words are valid and a new outgoing frame begins |
| slot_en | input | 1 | Enables slot 12 mirroring in both directions |
| rx_tag | input | 16 | Received tag word, bit 3 = slot 12 valid |
| rx_slot1 | input | 20 | Received slot 1 word, bit 2 = slot 12 request |
| rx_slot12 | input | 20 | Received slot 12 payload, bit 0 = GPIO interrupt |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data |
| tx_slot_tag | output | 1 | Outgoing slot 12 valid tag bit |
| tx_slot_data | output | 20 | Outgoing slot 12 payload |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends a request in one frame and then checks that the tag rises only in the frame after it and falls again in the frame that follows. A design that used the request from the current frame would assert the tag one frame early. It writes the output register between strobes and checks that the outgoing payload does not change. A design without the frame-aligned copy would tear an outgoing frame. It sets and clears the status bit in the same cycle, where a design with the wrong precedence would lose a codec interrupt. With the slot disabled, it sends a frame that is tagged valid, requested and interrupting. A leaky gate would show up there as a changed input register, a raised tag or a set status bit.

// File: rtl/acl_gpio_pkg.sv
package acl_gpio_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_GPI = 2'd0,
    REG_GPO = 2'd1,
    REG_STS = 2'd2,
    REG_CTL = 2'd3
  } reg_sel_e;

  // Tag word: bit (TAG_W-1) is frame valid, then one bit per slot 1..12 going down.
  function automatic int tag_bit_of(input int tag_w, input int slot_idx);
    return tag_w - 1 - slot_idx;
  endfunction

  // Slot 1 request field: slots 3..12 map onto bits 11..2.
  function automatic int req_bit_of(input int slot_idx);
    return 14 - slot_idx;
  endfunction
endpackage

// File: rtl/acl_gpio_rx_capture.sv
module acl_gpio_rx_capture #(
  parameter int SLOT_W  = 20,
  parameter int TAG_W   = 16,
  parameter int TAG_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic              slot_en,
  input  logic [TAG_W-1:0]  rx_tag,
  input  logic [SLOT_W-1:0] rx_slot,
  output logic [SLOT_W-1:0] gpi_q,
  output logic              int_hit
);
  logic capture;

  assign capture = frm_start && slot_en && rx_tag[TAG_BIT];
  assign int_hit = capture && rx_slot[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      gpi_q <= '0;
    end else if (capture) begin
      gpi_q <= rx_slot;
    end
  end
endmodule

// File: rtl/acl_gpio_tx_build.sv
module acl_gpio_tx_build #(
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic              slot_en,
  input  logic              req_in,
  input  logic [SLOT_W-1:0] gpo_q,
  output logic              req_q,
  output logic              tx_tag,
  output logic [SLOT_W-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      tx_tag  <= 1'b0;
      tx_data <= '0;
    end else if (frm_start) begin
      tx_tag  <= slot_en && req_q;
      tx_data <= gpo_q;
      req_q   <= req_in;
    end
  end
endmodule

// File: rtl/acl_gpio_regfile.sv
module acl_gpio_regfile
  import acl_gpio_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [SLOT_W-1:0] gpi_q,
  input  logic              int_hit,
  output logic [SLOT_W-1:0] gpo_q,
  output logic              sts_q,
  output logic              en_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic              sts_nxt;
  logic              en_nxt;
  logic              wr_gpo;
  logic              wr_sts;
  logic              wr_ctl;
  logic [DATA_W-1:0] rd_mux;

  assign wr_gpo = wr_en && (reg_sel_e'(wr_addr) == REG_GPO);
  assign wr_sts = wr_en && (reg_sel_e'(wr_addr) == REG_STS);
  assign wr_ctl = wr_en && (reg_sel_e'(wr_addr) == REG_CTL);

  always_comb begin
    sts_nxt = sts_q;
    if (wr_sts && wr_data[0]) sts_nxt = 1'b0;
    if (int_hit)              sts_nxt = 1'b1;
    en_nxt = wr_ctl ? wr_data[0] : en_q;
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_sel_e'(rd_addr))
      REG_GPI: rd_mux[SLOT_W-1:0] = gpi_q;
      REG_GPO: rd_mux[SLOT_W-1:0] = gpo_q;
      REG_STS: rd_mux[0]          = sts_q;
      REG_CTL: rd_mux[0]          = en_q;
      default: rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gpo_q   <= '0;
      sts_q   <= 1'b0;
      en_q    <= 1'b0;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_gpo) gpo_q <= wr_data[SLOT_W-1:0];
      sts_q   <= sts_nxt;
      en_q    <= en_nxt;
      irq     <= sts_nxt && en_nxt;
      rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/acl_gpio_shadow.sv
module acl_gpio_shadow
  import acl_gpio_pkg::*;
#(
  parameter int SLOT_W   = 20,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 16,
  parameter int SLOT_IDX = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic              slot_en,
  input  logic [TAG_W-1:0]  rx_tag,
  input  logic [SLOT_W-1:0] rx_slot1,
  input  logic [SLOT_W-1:0] rx_slot12,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_slot_tag,
  output logic [SLOT_W-1:0] tx_slot_data,
  output logic              irq
);
  localparam int TAG_BIT = tag_bit_of(TAG_W, SLOT_IDX);
  localparam int REQ_BIT = req_bit_of(SLOT_IDX);

  logic [SLOT_W-1:0] gpi_q;
  logic [SLOT_W-1:0] gpo_q;
  logic              int_hit;
  logic              req_q;
  logic              sts_q;
  logic              en_q;

  acl_gpio_rx_capture #(
    .SLOT_W (SLOT_W),
    .TAG_W  (TAG_W),
    .TAG_BIT(TAG_BIT)
  ) rx_i (
    .clk      (clk),
    .rst      (rst),
    .frm_start(frm_start),
    .slot_en  (slot_en),
    .rx_tag   (rx_tag),
    .rx_slot  (rx_slot12),
    .gpi_q    (gpi_q),
    .int_hit  (int_hit)
  );

  acl_gpio_tx_build #(
    .SLOT_W(SLOT_W)
  ) tx_i (
    .clk      (clk),
    .rst      (rst),
    .frm_start(frm_start),
    .slot_en  (slot_en),
    .req_in   (rx_slot1[REQ_BIT]),
    .gpo_q    (gpo_q),
    .req_q    (req_q),
    .tx_tag   (tx_slot_tag),
    .tx_data  (tx_slot_data)
  );

  acl_gpio_regfile #(
    .SLOT_W(SLOT_W),
    .DATA_W(DATA_W)
  ) regs_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .gpi_q  (gpi_q),
    .int_hit(int_hit),
    .gpo_q  (gpo_q),
    .sts_q  (sts_q),
    .en_q   (en_q),
    .rd_data(rd_data),
    .irq    (irq)
  );
endmodule

// File: rtl/acl_gpio_shadow_chk.sv
module acl_gpio_shadow_chk #(
  parameter int SLOT_W  = 20,
  parameter int TAG_W   = 16,
  parameter int TAG_BIT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_start,
  input logic              slot_en,
  input logic [TAG_W-1:0]  rx_tag,
  input logic [SLOT_W-1:0] rx_slot12,
  input logic [SLOT_W-1:0] gpi_q,
  input logic              req_q,
  input logic              sts_q,
  input logic              en_q,
  input logic              tx_slot_tag,
  input logic [SLOT_W-1:0] tx_slot_data,
  input logic              irq
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!tx_slot_tag && !irq && gpi_q == '0));

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (frm_start && slot_en && rx_tag[TAG_BIT]) |=> (gpi_q == $past(rx_slot12)));

  assert_hold_gpi_R3: assert property (@(posedge clk) disable iff (rst)
    (!(frm_start && slot_en && rx_tag[TAG_BIT])) |=> $stable(gpi_q));

  assert_tag_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
    (frm_start && !req_q) |=> !tx_slot_tag);

  assert_tx_frame_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    !frm_start |=> ($stable(tx_slot_tag) && $stable(tx_slot_data)));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (sts_q && en_q));

  assert_disabled_no_tag_R8: assert property (@(posedge clk) disable iff (rst)
    (frm_start && !slot_en) |=> (!tx_slot_tag && $stable(gpi_q)));
endmodule

bind acl_gpio_shadow acl_gpio_shadow_chk #(
  .SLOT_W (SLOT_W),
  .TAG_W  (TAG_W),
  .TAG_BIT(TAG_BIT)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .frm_start   (frm_start),
  .slot_en     (slot_en),
  .rx_tag      (rx_tag),
  .rx_slot12   (rx_slot12),
  .gpi_q       (gpi_q),
  .req_q       (req_q),
  .sts_q       (sts_q),
  .en_q        (en_q),
  .tx_slot_tag (tx_slot_tag),
  .tx_slot_data(tx_slot_data),
  .irq         (irq)
);

// File: tb/acl_gpio_shadow_tb_top.sv
module acl_gpio_shadow_tb_top;
  localparam logic [15:0] TAG_V12 = 16'h0008;
  localparam logic [19:0] REQ_12  = 20'h00004;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_start = 1'b0;
  logic        slot_en = 1'b1;
  logic [15:0] rx_tag = '0;
  logic [19:0] rx_slot1 = '0;
  logic [19:0] rx_slot12 = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tx_slot_tag;
  logic [19:0] tx_slot_data;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  acl_gpio_shadow dut_i (
    .clk(clk), .rst(rst), .frm_start(frm_start), .slot_en(slot_en),
    .rx_tag(rx_tag), .rx_slot1(rx_slot1), .rx_slot12(rx_slot12),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_slot_tag(tx_slot_tag), .tx_slot_data(tx_slot_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] tag, input logic [19:0] s1,
                       input logic [19:0] s12, input logic en);
    rx_tag = tag; rx_slot1 = s1; rx_slot12 = s12; slot_en = en; frm_start = 1'b1;
    @(negedge clk);
    frm_start = 1'b0; rx_tag = '0; rx_slot1 = '0; rx_slot12 = '0; slot_en = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
    rd_addr = a;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    check("R1 tag", {31'd0, tx_slot_tag}, 32'd0);
    check("R1 data", {12'd0, tx_slot_data}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    for (int a = 0; a < 4; a++) rd_check("R1 reg", 2'(a), 32'd0);
  endtask

  task automatic t_capture;
    frame(TAG_V12, '0, 20'hABCDE, 1'b1);
    rd_check("R2 gpi", 2'd0, 32'h000ABCDE);
    rd_check("R2 no status", 2'd2, 32'd0);
    frame(16'h0000, '0, 20'h12345, 1'b1);
    rd_check("R3 gpi held", 2'd0, 32'h000ABCDE);
  endtask

  task automatic t_request;
    frame(16'h0000, REQ_12, '0, 1'b1);
    check("R4 not same frame", {31'd0, tx_slot_tag}, 32'd0);
    frame(16'h0000, '0, '0, 1'b1);
    check("R4 next frame", {31'd0, tx_slot_tag}, 32'd1);
    @(negedge clk);
    check("R4 held between strobes", {31'd0, tx_slot_tag}, 32'd1);
    frame(16'h0000, '0, '0, 1'b1);
    check("R4 drops", {31'd0, tx_slot_tag}, 32'd0);
  endtask

  task automatic t_gpo;
    wr(2'd1, 32'hFFF55AA5);
    rd_check("R5 gpo readback", 2'd1, 32'h00055AA5);
    check("R5 tx unchanged", {12'd0, tx_slot_data}, 32'd0);
    frame(16'h0000, '0, '0, 1'b1);
    check("R5 tx loaded", {12'd0, tx_slot_data}, 32'h00055AA5);
    wr(2'd1, 32'h000F0F0F);
    check("R5 no tear", {12'd0, tx_slot_data}, 32'h00055AA5);
    frame(16'h0000, '0, '0, 1'b1);
    check("R5 next frame", {12'd0, tx_slot_data}, 32'h000F0F0F);
  endtask

  task automatic t_irq;
    wr(2'd3, 32'd1);
    rd_check("R7 ctl", 2'd3, 32'd1);
    check("R7 irq idle", {31'd0, irq}, 32'd0);
    frame(TAG_V12, '0, 20'h00001, 1'b1);
    check("R7 irq set", {31'd0, irq}, 32'd1);
    rd_check("R6 status set", 2'd2, 32'd1);
    frame(TAG_V12, '0, 20'h00010, 1'b1);
    rd_check("R6 sticky", 2'd2, 32'd1);
    wr(2'd2, 32'd1);
    check("R6 irq cleared", {31'd0, irq}, 32'd0);
    rd_check("R6 status cleared", 2'd2, 32'd0);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'd1;
    frame(TAG_V12, '0, 20'h00001, 1'b1);
    wr_en = 1'b0;
    rd_check("R6 set beats clear", 2'd2, 32'd1);
    wr(2'd3, 32'd0);
    check("R7 irq masked", {31'd0, irq}, 32'd0);
    rd_check("R7 status kept", 2'd2, 32'd1);
    wr(2'd2, 32'd1);
    rd_check("R6 cleared again", 2'd2, 32'd0);
  endtask

  task automatic t_disable;
    frame(16'h0000, REQ_12, '0, 1'b1);
    frame(TAG_V12, REQ_12, 20'h00003, 1'b0);
    check("R8 tag off", {31'd0, tx_slot_tag}, 32'd0);
    rd_check("R8 gpi held", 2'd0, 32'h00000001);
    rd_check("R8 status clear", 2'd2, 32'd0);
  endtask

  task automatic t_read_latency;
    rd_addr = 2'd1;
    @(negedge clk);
    check("R9 gpo sel", rd_data, 32'h000F0F0F);
    rd_addr = 2'd0;
    #2;
    check("R9 before edge", rd_data, 32'h000F0F0F);
    @(negedge clk);
    check("R9 after edge", rd_data, 32'h00000001);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_capture();
    t_request();
    t_gpo();
    t_irq();
    t_disable();
    t_read_latency();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule